// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block takes configuration words for two frequency-synthesizer channels from a three-wire serial interface made of a serial clock, a data line and a load-enable line. Each rising edge of the serial clock pushes one data bit into a 23-bit shift register, most significant bit first. When load enable rises, the word held in the register is copied into one of four latch groups. The two bits that arrive last pick the group.

Each channel owns two latch groups. The reference group holds the reference-divider ratio, the charge-pump current select and a two-bit test/monitor select. The feedback group holds the swallow count, the programmable-counter ratio, the lock-output select, the prescaler-modulus select and the phase-detector polarity bit. Channel 0 is the lower-band channel and channel 1 the higher-band channel. The three serial inputs are sampled on the system clock `clk` and are taken as already synchronized to it. A one-cycle strobe for each group tells the downstream divider logic that new settings have been latched.

Top module: `cfg3w_loader`

## Requirements
- R1: On each system-clock cycle in which a rising edge of `ser_clk` is detected while `ser_le` is low, the 23-bit shift register moves up one place and takes `ser_data` into word position 1 (register bit 0). After 23 such edges, the bit sent first sits at position 23.
- R2: A rising edge of `ser_clk` detected while `ser_le` is high does not change the shift register, so a later load delivers the word held before that edge.
- R3: Position 1 is the channel bit (0 = channel 0, 1 = channel 1). Position 2 is the group bit (0 = reference group, 1 = feedback group). Together they select exactly one of the four latch groups.
- R4: In a reference word, positions 3 and 4 are `test_sel` bits 0 and 1. Positions 5 to 18 are the 14-bit reference ratio, least significant bit first. Position 19 is `cp_hi`. Positions 20 to 23 are ignored.
- R5: In a feedback word, position 3 is `lock_sel`, position 4 is `pre_sel` and position 5 is `phase_pol`. Positions 6 to 12 are the 7-bit swallow count and positions 13 to 23 the 11-bit programmable ratio, each least significant bit first.
- R6: The addressed group updates on the clock edge at which a rising edge of `ser_le` is first seen, and the new values show at the outputs in the following cycle. Holding `ser_le` high causes no further update.
- R7: The update strobe of the written group (`ref_upd[ch]` or `fb_upd[ch]`) is high for exactly one cycle per load. At most one strobe is high in any cycle.
- R8: Latch groups that the current load does not address keep their values.
- R9: While `rst_n` is low, every latched field and every strobe is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, synchronized to `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load enable; rising edge commits the word |
| ref_div | output | 2x14 | Reference-divider ratio per channel |
| cp_hi | output | 2 | Charge-pump high-current select per channel |
| test_sel | output | 2x2 | Test/monitor select per channel |
| lock_sel | output | 2 | Lock-output select per channel |
| pre_sel | output | 2 | Prescaler-modulus select per channel |
| phase_pol | output | 2 | Phase-detector polarity per channel |
| swallow | output | 2x7 | Swallow count per channel |
| prog | output | 2x11 | Programmable-counter ratio per channel |
| ref_upd | output | 2 | One-cycle strobe: reference group written |
| fb_upd | output | 2 | One-cycle strobe: feedback group written |

## Verification
A shift register that slips by one place shows up on the next load as a wrong group strobe or a field shifted by one bit. It appears in the cycle after the `ser_le` rise. A decode fault makes the wrong strobe pulse and changes a group that should have held its value, and the full-output comparison after every load exposes it at once. A shift accepted while load enable is high changes the address bits of the next reload, so that reload strobes a different group than expected.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  parameter int WORD_W = 23;
  parameter int TST_W  = 2;
  parameter int R_W    = 14;
  parameter int A_W    = 7;
  parameter int N_W    = 11;
  parameter int NUM_CH = 2;

  // register bit = word position - 1
  localparam int CH_BIT    = 0;
  localparam int GRP_BIT   = 1;
  localparam int REF_T_LSB = 2;
  localparam int REF_R_LSB = REF_T_LSB + TST_W;
  localparam int REF_CS    = REF_R_LSB + R_W;
  localparam int FB_LDS    = 2;
  localparam int FB_SW     = FB_LDS + 1;
  localparam int FB_FC     = FB_SW + 1;
  localparam int FB_A_LSB  = FB_FC + 1;
  localparam int FB_N_LSB  = FB_A_LSB + A_W;
  localparam int NUM_GRP   = 2 * NUM_CH;

  typedef struct packed {
    logic [TST_W-1:0] tst;
    logic [R_W-1:0]   r;
    logic             cs;
  } ref_t;

  typedef struct packed {
    logic           lds;
    logic           sw;
    logic           fc;
    logic [A_W-1:0] a;
    logic [N_W-1:0] n;
  } fb_t;

  function automatic ref_t unpack_ref(input logic [WORD_W-1:0] w);
    ref_t f;
    f.tst = w[REF_T_LSB +: TST_W];
    f.r   = w[REF_R_LSB +: R_W];
    f.cs  = w[REF_CS];
    return f;
  endfunction

  function automatic fb_t unpack_fb(input logic [WORD_W-1:0] w);
    fb_t f;
    f.lds = w[FB_LDS];
    f.sw  = w[FB_SW];
    f.fc  = w[FB_FC];
    f.a   = w[FB_A_LSB +: A_W];
    f.n   = w[FB_N_LSB +: N_W];
    return f;
  endfunction

  // one-hot target: index = {group bit, channel bit}
  function automatic logic [NUM_GRP-1:0] target_of(input logic grp, input logic ch);
    logic [NUM_GRP-1:0] t;
    t = '0;
    t[{grp, ch}] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/cfg3w_rise.sv
module cfg3w_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_we,
  input  logic              fb_we,
  input  logic [WORD_W-1:0] word,
  output ref_t              ref_q,
  output fb_t               fb_q,
  output logic              ref_stb,
  output logic              fb_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      fb_q    <= '0;
      ref_stb <= 1'b0;
      fb_stb  <= 1'b0;
    end else begin
      ref_stb <= ref_we;
      fb_stb  <= fb_we;
      if (ref_we) ref_q <= unpack_ref(word);
      if (fb_we)  fb_q  <= unpack_fb(word);
    end
  end
endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
  import cfg3w_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_data,
  input  logic                        ser_le,
  output logic [NUM_CH-1:0][R_W-1:0]  ref_div,
  output logic [NUM_CH-1:0]           cp_hi,
  output logic [NUM_CH-1:0][TST_W-1:0] test_sel,
  output logic [NUM_CH-1:0]           lock_sel,
  output logic [NUM_CH-1:0]           pre_sel,
  output logic [NUM_CH-1:0]           phase_pol,
  output logic [NUM_CH-1:0][A_W-1:0]  swallow,
  output logic [NUM_CH-1:0][N_W-1:0]  prog,
  output logic [NUM_CH-1:0]           ref_upd,
  output logic [NUM_CH-1:0]           fb_upd
);
  logic                clk_rise;
  logic                le_rise;
  logic                shift_fire;
  logic [WORD_W-1:0]   shift_word;
  logic [NUM_GRP-1:0]  grp_we;

  cfg3w_rise u_clk_edge (.clk(clk), .rst_n(rst_n), .lvl(ser_clk), .rise(clk_rise));
  cfg3w_rise u_le_edge  (.clk(clk), .rst_n(rst_n), .lvl(ser_le),  .rise(le_rise));

  // shifting is frozen while load enable is high
  assign shift_fire = clk_rise & ~ser_le;

  cfg3w_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_fire), .din(ser_data), .word(shift_word)
  );

  assign grp_we = le_rise ? target_of(shift_word[GRP_BIT], shift_word[CH_BIT]) : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ref_t ref_q;
    fb_t  fb_q;

    cfg3w_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .ref_we(grp_we[ch]), .fb_we(grp_we[NUM_CH + ch]),
      .word(shift_word),
      .ref_q(ref_q), .fb_q(fb_q),
      .ref_stb(ref_upd[ch]), .fb_stb(fb_upd[ch])
    );

    assign ref_div[ch]   = ref_q.r;
    assign cp_hi[ch]     = ref_q.cs;
    assign test_sel[ch]  = ref_q.tst;
    assign lock_sel[ch]  = fb_q.lds;
    assign pre_sel[ch]   = fb_q.sw;
    assign phase_pol[ch] = fb_q.fc;
    assign swallow[ch]   = fb_q.a;
    assign prog[ch]      = fb_q.n;
  end
endmodule

// File: rtl/cfg3w_loader_chk.sv
module cfg3w_loader_chk
  import cfg3w_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ser_le,
  input logic                       ser_data,
  input logic                       shift_fire,
  input logic [WORD_W-1:0]          shift_word,
  input logic [NUM_CH-1:0]          ref_upd,
  input logic [NUM_CH-1:0]          fb_upd,
  input logic [NUM_CH-1:0][R_W-1:0] ref_div,
  input logic [NUM_CH-1:0][A_W-1:0] swallow,
  input logic [NUM_CH-1:0][N_W-1:0] prog
);
  assert_shift_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> (shift_word[0] == $past(ser_data)));

  assert_no_shift_le_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |=> $stable(shift_word));

  assert_strobe_after_le_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({ref_upd, fb_upd} != '0) |-> $past(ser_le));

  assert_single_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_upd, fb_upd}));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ({ref_upd, fb_upd} != '0) |=> ({ref_upd, fb_upd} == '0));

  assert_keep_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_upd == '0) |-> $stable(ref_div));

  assert_keep_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_upd == '0) |-> $stable({swallow, prog}));
endmodule

bind cfg3w_loader cfg3w_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_le(ser_le), .ser_data(ser_data),
  .shift_fire(shift_fire), .shift_word(shift_word),
  .ref_upd(ref_upd), .fb_upd(fb_upd),
  .ref_div(ref_div), .swallow(swallow), .prog(prog)
);

// File: tb/cfg3w_loader_tb.sv
module cfg3w_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [1:0][13:0] ref_div;
  logic [1:0]       cp_hi;
  logic [1:0][1:0]  test_sel;
  logic [1:0]       lock_sel, pre_sel, phase_pol;
  logic [1:0][6:0]  swallow;
  logic [1:0][10:0] prog;
  logic [1:0]       ref_upd, fb_upd;

  always #2 clk = ~clk;

  cfg3w_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_div(ref_div), .cp_hi(cp_hi), .test_sel(test_sel), .lock_sel(lock_sel),
    .pre_sel(pre_sel), .phase_pol(phase_pol), .swallow(swallow), .prog(prog),
    .ref_upd(ref_upd), .fb_upd(fb_upd)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected model
  logic [1:0][13:0] m_ref;
  logic [1:0]       m_cs;
  logic [1:0][1:0]  m_tst;
  logic [1:0]       m_lds, m_sw, m_fc;
  logic [1:0][6:0]  m_a;
  logic [1:0][10:0] m_n;

  // word builders: position p of the word is bit p-1
  function automatic logic [22:0] mk_ref(input bit ch, input logic [1:0] t,
                                         input logic [13:0] r, input bit cs, input logic [3:0] junk);
    logic [22:0] w = '0;
    w[0] = ch; w[1] = 1'b0;
    w[2] = t[0]; w[3] = t[1];
    for (int i = 0; i < 14; i++) w[4 + i] = r[i];
    w[18] = cs;
    for (int i = 0; i < 4; i++) w[19 + i] = junk[i];
    return w;
  endfunction

  function automatic logic [22:0] mk_fb(input bit ch, input bit lds, input bit sw, input bit fc,
                                        input logic [6:0] a, input logic [10:0] n);
    logic [22:0] w = '0;
    w[0] = ch; w[1] = 1'b1;
    w[2] = lds; w[3] = sw; w[4] = fc;
    for (int i = 0; i < 7; i++)  w[5 + i] = a[i];
    for (int i = 0; i < 11; i++) w[12 + i] = n[i];
    return w;
  endfunction

  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    mk_ref(1'b0, 2'b01, 14'h2A5C, 1'b1, 4'hF),
    mk_fb (1'b1, 1'b1, 1'b0, 1'b1, 7'h55, 11'h5A3),
    mk_ref(1'b1, 2'b10, 14'h3FFF, 1'b0, 4'hA),
    mk_fb (1'b0, 1'b0, 1'b1, 1'b0, 7'h7F, 11'h7FF),
    mk_fb (1'b1, 1'b0, 1'b1, 1'b1, 7'h00, 11'h003),
    mk_ref(1'b0, 2'b11, 14'h0003, 1'b0, 4'h0)
  };

  task automatic model_clear();
    m_ref = '0; m_cs = '0; m_tst = '0; m_lds = '0; m_sw = '0; m_fc = '0; m_a = '0; m_n = '0;
  endtask

  task automatic model_apply(input logic [22:0] w);
    int ch = int'(w[0]);
    if (!w[1]) begin
      m_tst[ch] = {w[3], w[2]};
      for (int i = 0; i < 14; i++) m_ref[ch][i] = w[4 + i];
      m_cs[ch] = w[18];
    end else begin
      m_lds[ch] = w[2]; m_sw[ch] = w[3]; m_fc[ch] = w[4];
      for (int i = 0; i < 7; i++)  m_a[ch][i] = w[5 + i];
      for (int i = 0; i < 11; i++) m_n[ch][i] = w[12 + i];
    end
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_fields(input string req);
    check(req, 128'({ref_div, cp_hi, test_sel, lock_sel, pre_sel, phase_pol, swallow, prog}),
               128'({m_ref, m_cs, m_tst, m_lds, m_sw, m_fc, m_a, m_n}));
  endtask

  function automatic logic [3:0] exp_stb(input logic [22:0] w);
    logic [3:0] s = '0;   // {ref_upd, fb_upd}
    if (!w[1]) s[2 + int'(w[0])] = 1'b1;
    else       s[int'(w[0])]     = 1'b1;
    return s;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) send_bit(w[i]);   // R1: MSB first
  endtask

  task automatic load_and_check(input logic [22:0] w);
    send_word(w);
    model_apply(w);
    @(negedge clk); ser_le = 1'b1;
    @(negedge clk);
    check("R3 R7 strobe of addressed group", 128'({ref_upd, fb_upd}), 128'(exp_stb(w)));
    check_fields("R4 R5 R6 R8 latched fields");
    @(negedge clk);
    check("R7 strobe lasts one cycle", 128'({ref_upd, fb_upd}), 128'(0));
    ser_le = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_fields("R9 reset fields");
    check("R9 reset strobes", 128'({ref_upd, fb_upd}), 128'(0));

    // vector table walk: R1 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) load_and_check(VEC[v]);

    // R6 and R2: hold load enable high, shift one bit, then reload
    @(negedge clk); ser_le = 1'b1;
    @(negedge clk);
    check("R6 reload strobe", 128'({ref_upd, fb_upd}), 128'(exp_stb(VEC[5])));
    send_bit(1'b1);
    send_bit(1'b1);
    check("R6 no repeat update while held", 128'({ref_upd, fb_upd}), 128'(0));
    @(negedge clk); ser_le = 1'b0;
    @(negedge clk); ser_le = 1'b1;
    @(negedge clk);
    check("R2 shift ignored under load enable", 128'({ref_upd, fb_upd}), 128'(exp_stb(VEC[5])));
    check_fields("R2 fields after reload");
    @(negedge clk); ser_le = 1'b0;

    // R9: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    model_clear();
    check_fields("R9 fields cleared by reset");
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule